// File: doc/BRIEF.md
# Extended-Precision Load Converter with Denormal Screening

This block widens a floating-point load operand into the 80-bit extended register format. A 32-bit single or a 64-bit double operand is re-encoded. It is not flushed. A tiny (denormal) single or double is renormalized, because the wider exponent range of the extended format can represent it exactly as a normal number. An 80-bit operand is copied through unchanged. The result appears one clock after the request, together with a register write strobe and a stack push strobe.

The block also screens operands for the denormal-operand condition. It screens the load operand, and it screens a second operand on a separate check port, which the arithmetic path uses to vet its sources. Every hit sets a sticky denormal flag. The mask bit in the control word selects the response. When the mask is set, the load completes normally. When the mask is clear, a handler request pulse is issued and the register, the stack pointer and the held output value all stay as they were.

Top module: `fpx_load_conv`

## Requirements
- R1: A load with format code 0 takes a single from bits [31:0] (sign 31, 8-bit exponent, 23-bit fraction, bias 127). A normal value gets extended exponent e+16256 and significand {1, fraction, zeros}. A signed zero gives a signed extended zero. An all-ones exponent gives extended exponent 7FFF with the integer bit set and the fraction left-aligned below it.
- R2: A load with format code 1 takes a double from bits [63:0] (sign 63, 11-bit exponent, 52-bit fraction, bias 1023). The same rules as R1 apply, with a normal exponent offset of 15360.
- R3: A load with format code 2 or 3 writes the 80-bit operand unchanged, and never raises the denormal condition, even when its exponent is zero and its significand is nonzero.
- R4: A single or double with a zero exponent and a nonzero fraction is denormal. Its significand is shifted left by n so that the leading one reaches bit 63, where n is the leading-zero count of the fraction plus one. Its extended exponent is 16384 − bias − n.
- R5: With the mask (control word bit 1) set, a denormal hit sets the flag and the load completes with write and push strobes.
- R6: With the mask clear, a denormal hit sets the flag and pulses the handler request for one cycle. No write or push strobe is issued that cycle, and the output value holds its previous contents.
- R7: An operand on the check port is screened in any format, where an extended operand is denormal when its exponent is zero and its 64-bit significand is nonzero. A hit follows the same flag and mask handling. A check never writes. An unmasked check hit also suppresses a load presented in the same cycle.
- R8: The denormal flag is sticky. Only the clear input clears it. A denormal hit in the same cycle as a clear leaves the flag set.
- R9: Outputs are registered with one cycle of latency. The valid output pulses for each load request, whether the load commits or traps. A check alone does not pulse it.
- R10: In reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request |
| req_fmt | input | 2 | Load format: 0 single, 1 double, 2/3 extended |
| req_data | input | 80 | Raw load operand, right-aligned |
| chk_valid | input | 1 | Operand screening request |
| chk_fmt | input | 2 | Format of the screened operand |
| chk_data | input | 80 | Screened operand, right-aligned |
| ctrl_word | input | 16 | Control word; bit 1 masks the denormal condition |
| clr_exc | input | 1 | Clears the sticky denormal flag |
| out_valid | output | 1 | One-cycle pulse per load request |
| out_value | output | 80 | Converted extended value |
| reg_we | output | 1 | Destination register write strobe |
| stack_push | output | 1 | Stack pointer push strobe |
| status_de | output | 1 | Sticky denormal flag (status bit 1) |
| handler_req | output | 1 | Unmasked denormal trap pulse |

## Verification
The bound checker watches the control relations on every cycle. These are: write and push move together; a trap never coexists with a write; the held value is stable whenever nothing is written; a trap implies a clear mask and a set flag; the flag cannot drop without a clear; and an extended load alone never traps. The exact bit patterns are left to the scoreboard scenarios. These include renormalized exponents at the extremes of the leading-zero count, NaN payload alignment, signed zeros, and the same-cycle interactions between a check hit, a load and a clear.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXT_W     = 80;
  localparam int EXT_EXP_W = 15;
  localparam int EXT_SIG_W = 64;
  localparam int EXT_BIAS  = 16383;
  localparam int MASK_BIT  = 1;

  typedef enum logic [1:0] {
    FMT_SGL     = 2'd0,
    FMT_DBL     = 2'd1,
    FMT_EXT     = 2'd2,
    FMT_EXT_ALT = 2'd3
  } fmt_e;

  typedef struct packed {
    logic                 sign;
    logic [EXT_EXP_W-1:0] expo;
    logic [EXT_SIG_W-1:0] sig;
  } ext_t;
endpackage

// File: rtl/fpx_lzc.sv
module fpx_lzc #(
  parameter int W  = 23,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  logic found;

  always_comb begin
    cnt   = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (vec[i]) found = 1'b1;
        else        cnt   = cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/fpx_widen.sv
module fpx_widen
  import fpx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int SRC_W    = 1 + EXP_W + FRAC_W,
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1,
  localparam int PAD      = EXT_SIG_W - 1 - FRAC_W,
  localparam int NORM_OFF = EXT_BIAS - BIAS,
  localparam int DEN_BASE = EXT_BIAS + 1 - BIAS,
  localparam int LZW      = $clog2(FRAC_W + 1)
) (
  input  logic [SRC_W-1:0] src,
  output ext_t             res,
  output logic             is_den
);
  logic              sgn;
  logic [EXP_W-1:0]  e;
  logic [FRAC_W-1:0] f;
  logic [LZW-1:0]    lz;
  logic [6:0]        sh;
  logic              e_zero, e_ones, f_nz;

  assign sgn    = src[SRC_W-1];
  assign e      = src[SRC_W-2:FRAC_W];
  assign f      = src[FRAC_W-1:0];
  assign e_zero = (e == '0);
  assign e_ones = &e;
  assign f_nz   = |f;
  assign is_den = e_zero & f_nz;

  fpx_lzc #(.W(FRAC_W)) u_lzc (.vec(f), .cnt(lz));

  assign sh = 7'(lz) + 7'd1;

  always_comb begin
    res.sign = sgn;
    if (e_ones) begin
      res.expo = '1;
      res.sig  = {1'b1, f, {PAD{1'b0}}};
    end else if (e_zero && !f_nz) begin
      res.expo = '0;
      res.sig  = '0;
    end else if (e_zero) begin
      res.sig  = {1'b0, f, {PAD{1'b0}}} << sh;
      res.expo = EXT_EXP_W'(DEN_BASE) - {{(EXT_EXP_W-7){1'b0}}, sh};
    end else begin
      res.expo = EXT_EXP_W'(NORM_OFF) + {{(EXT_EXP_W-EXP_W){1'b0}}, e};
      res.sig  = {1'b1, f, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fpx_screen.sv
module fpx_screen
  import fpx_pkg::*;
(
  input  logic [1:0]       fmt,
  input  logic [EXT_W-2:0] opnd,
  output logic             den
);
  always_comb begin
    unique case (fmt)
      FMT_SGL: den = (opnd[30:23] == '0) && (opnd[22:0] != '0);
      FMT_DBL: den = (opnd[62:52] == '0) && (opnd[51:0] != '0);
      default: den = (opnd[78:64] == '0) && (opnd[63:0] != '0);
    endcase
  end
endmodule

// File: rtl/fpx_load_conv.sv
module fpx_load_conv
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_fmt,
  input  logic [EXT_W-1:0]  req_data,
  input  logic              chk_valid,
  input  logic [1:0]        chk_fmt,
  input  logic [EXT_W-1:0]  chk_data,
  input  logic [15:0]       ctrl_word,
  input  logic              clr_exc,
  output logic              out_valid,
  output logic [EXT_W-1:0]  out_value,
  output logic              reg_we,
  output logic              stack_push,
  output logic              status_de,
  output logic              handler_req
);
  ext_t             cv_s, cv_d;
  logic             den_s, den_d, ck_den, ld_den;
  logic [EXT_W-1:0] conv;
  logic             masked, hit, trap, commit;
  logic             unused_bits;

  assign unused_bits = ^{ctrl_word[15:2], ctrl_word[0], chk_data[EXT_W-1]};

  fpx_widen #(.EXP_W(8),  .FRAC_W(23)) u_sgl (
    .src(req_data[31:0]), .res(cv_s), .is_den(den_s));
  fpx_widen #(.EXP_W(11), .FRAC_W(52)) u_dbl (
    .src(req_data[63:0]), .res(cv_d), .is_den(den_d));
  fpx_screen u_scr (.fmt(chk_fmt), .opnd(chk_data[EXT_W-2:0]), .den(ck_den));

  always_comb begin
    unique case (req_fmt)
      FMT_SGL: begin conv = cv_s;     ld_den = den_s; end
      FMT_DBL: begin conv = cv_d;     ld_den = den_d; end
      default: begin conv = req_data; ld_den = 1'b0;  end
    endcase
  end

  assign masked = ctrl_word[MASK_BIT];
  assign hit    = (req_valid & ld_den) | (chk_valid & ck_den);
  assign trap   = hit & ~masked;
  assign commit = req_valid & ~trap;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_value   <= '0;
      reg_we      <= 1'b0;
      stack_push  <= 1'b0;
      status_de   <= 1'b0;
      handler_req <= 1'b0;
    end else begin
      out_valid   <= req_valid;
      reg_we      <= commit;
      stack_push  <= commit;
      handler_req <= trap;
      status_de   <= (status_de & ~clr_exc) | hit;
      if (commit) out_value <= conv;
    end
  end
endmodule

// File: rtl/fpx_load_conv_chk.sv
module fpx_load_conv_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        ld_ext,
  input logic        chk_valid,
  input logic        dm,
  input logic        clr_exc,
  input logic        out_valid,
  input logic [79:0] out_value,
  input logic        reg_we,
  input logic        stack_push,
  input logic        status_de,
  input logic        handler_req
);
  // R5
  we_push_pair_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> stack_push);
  // R5
  push_we_pair_chk: assert property (@(posedge clk) disable iff (rst)
    stack_push |-> reg_we);
  // R6
  trap_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    handler_req |-> !reg_we && !stack_push);
  // R6
  hold_value_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_we |-> $stable(out_value));
  // R6
  trap_needs_unmask_chk: assert property (@(posedge clk) disable iff (rst)
    handler_req |-> !$past(dm));
  // R8
  trap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    handler_req |-> status_de);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    status_de && !clr_exc |=> status_de);
  // R9
  we_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |-> out_valid);
  // R3
  ext_load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && ld_ext && !chk_valid |=> !handler_req);
endmodule

bind fpx_load_conv fpx_load_conv_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .ld_ext(req_fmt[1]),
  .chk_valid(chk_valid), .dm(ctrl_word[1]), .clr_exc(clr_exc),
  .out_valid(out_valid), .out_value(out_value), .reg_we(reg_we),
  .stack_push(stack_push), .status_de(status_de), .handler_req(handler_req));

// File: tb/sim_fpx_load_conv.sv
`timescale 1ns/1ps
module sim_fpx_load_conv;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, chk_valid = 1'b0, clr_exc = 1'b0;
  logic [1:0]  req_fmt = 2'd0, chk_fmt = 2'd0;
  logic [79:0] req_data = '0, chk_data = '0;
  logic [15:0] ctrl_word = '0;
  logic        out_valid, reg_we, stack_push, status_de, handler_req;
  logic [79:0] out_value;

  always #2.5 clk = ~clk;

  fpx_load_conv u0 (.*);

  typedef struct {
    logic ov, we, hr, de;
    logic [79:0] val;
    string tag;
  } exp_t;
  exp_t q[$];

  int n_chk = 0, n_bad = 0;
  logic        m_de = 1'b0;
  logic [79:0] m_val = '0;

  task automatic check(input logic ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [79:0] ref_widen(input int ew, input int fw, input logic [63:0] d);
    logic        s;
    logic [63:0] e, f, sig;
    int          bias, ex;
    s    = d[ew + fw];
    e    = (d >> fw) & ((64'd1 << ew) - 64'd1);
    f    = d & ((64'd1 << fw) - 64'd1);
    bias = (1 << (ew - 1)) - 1;
    if (e == (64'd1 << ew) - 64'd1) return {s, 15'h7FFF, (64'd1 << 63) | (f << (63 - fw))};
    if (e == 0 && f == 0) return {s, 79'd0};
    if (e == 0) begin
      sig = f << (63 - fw);
      ex  = 16384 - bias;
      while (!sig[63]) begin sig = sig << 1; ex--; end
      return {s, 15'(ex), sig};
    end
    ex = int'(e) - bias + 16383;
    return {s, 15'(ex), (64'd1 << 63) | (f << (63 - fw))};
  endfunction

  function automatic logic ref_den(input logic [1:0] fmt, input logic [79:0] d);
    if (fmt == 2'd0) return d[30:23] == 0 && d[22:0] != 0;
    if (fmt == 2'd1) return d[62:52] == 0 && d[51:0] != 0;
    return d[78:64] == 0 && d[63:0] != 0;
  endfunction

  task automatic step(input logic rv, input logic [1:0] rf, input logic [79:0] rd,
                      input logic cv, input logic [1:0] cf, input logic [79:0] cd,
                      input logic dm, input logic clr, input string tag);
    logic ldd, ckd, hit, trap, com;
    exp_t e;
    @(negedge clk);
    req_valid = rv; req_fmt = rf; req_data = rd;
    chk_valid = cv; chk_fmt = cf; chk_data = cd;
    ctrl_word = {14'h0, dm, 1'b0}; clr_exc = clr;
    ldd  = rv && !rf[1] && ref_den(rf, rd);
    ckd  = cv && ref_den(cf, cd);
    hit  = ldd || ckd;
    trap = hit && !dm;
    com  = rv && !trap;
    if (com) m_val = rf[1] ? rd : (rf[0] ? ref_widen(11, 52, rd[63:0])
                                         : ref_widen(8, 23, {32'd0, rd[31:0]}));
    m_de = (m_de && !clr) || hit;
    e.ov = rv; e.we = com; e.hr = trap; e.de = m_de; e.val = m_val; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic ld(input logic [1:0] f, input logic [79:0] d, input logic dm, input string tag);
    step(1'b1, f, d, 1'b0, 2'd0, 80'd0, dm, 1'b0, tag);
  endtask

  task automatic idle(input logic clr, input string tag);
    step(1'b0, 2'd0, 80'd0, 1'b0, 2'd0, 80'd0, 1'b1, clr, tag);
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(out_valid == e.ov, e.tag, "out_valid (R9)", {79'd0, out_valid}, {79'd0, e.ov});
      check(reg_we == e.we, e.tag, "reg_we", {79'd0, reg_we}, {79'd0, e.we});
      check(stack_push == e.we, e.tag, "stack_push", {79'd0, stack_push}, {79'd0, e.we});
      check(handler_req == e.hr, e.tag, "handler_req", {79'd0, handler_req}, {79'd0, e.hr});
      check(status_de == e.de, e.tag, "status_de", {79'd0, status_de}, {79'd0, e.de});
      check(out_value == e.val, e.tag, "out_value", out_value, e.val);
    end
  end

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    check({out_valid, reg_we, stack_push, status_de, handler_req} == 5'd0, "R10", "ctl",
          {75'd0, out_valid, reg_we, stack_push, status_de, handler_req}, 80'd0);
    check(out_value == 80'd0, "R10", "value", out_value, 80'd0);
    @(negedge clk); rst = 1'b0;

    // R1 single normals, zeros, specials
    ld(2'd0, 80'h3F800000, 1'b1, "R1");
    ld(2'd0, 80'h80000000, 1'b1, "R1");
    ld(2'd0, 80'h7F800000, 1'b1, "R1");
    ld(2'd0, 80'h7FC00001, 1'b1, "R1");
    ld(2'd0, 80'hC2F6E979, 1'b0, "R1");
    // R2 doubles
    ld(2'd1, 80'h3FF0000000000000, 1'b1, "R2");
    ld(2'd1, 80'h8000000000000000, 1'b0, "R2");
    ld(2'd1, 80'hFFF0000000000000, 1'b1, "R2");
    ld(2'd1, 80'h7FF8000000000001, 1'b1, "R2");
    ld(2'd1, 80'h0010000000000000, 1'b0, "R2");
    // R3 extended passthrough, denormal exempt even unmasked
    ld(2'd2, 80'h0000_0000_0000_0000_1234, 1'b0, "R3");
    ld(2'd3, 80'h8000_7FFF_FFFF_FFFF_FFFF, 1'b0, "R3");
    ld(2'd2, 80'h4000_C90F_DAA2_2168_C235, 1'b0, "R3");
    // R4 / R5 masked denormals, extreme shift counts
    ld(2'd0, 80'h00000001, 1'b1, "R4");
    ld(2'd0, 80'h807FFFFF, 1'b1, "R4");
    ld(2'd0, 80'h00400000, 1'b1, "R5");
    ld(2'd1, 80'h0000000000000001, 1'b1, "R4");
    ld(2'd1, 80'h800FFFFFFFFFFFFF, 1'b1, "R5");
    // R8 clear, then clean load keeps it clear, then sticky after a hit
    idle(1'b1, "R8");
    ld(2'd0, 80'h3F800000, 1'b1, "R8");
    ld(2'd0, 80'h00000010, 1'b1, "R8");
    ld(2'd1, 80'h3FF0000000000000, 1'b1, "R8");
    idle(1'b0, "R8");
    idle(1'b1, "R8");
    // R6 unmasked denormal: trap, hold value
    ld(2'd0, 80'h40490FDB, 1'b0, "R6");
    ld(2'd0, 80'h00000003, 1'b0, "R6");
    idle(1'b0, "R6");
    ld(2'd1, 80'h0000000000ABCDEF, 1'b0, "R6");
    // R7 check port
    idle(1'b1, "R7");
    step(1'b0, 2'd0, 80'd0, 1'b1, 2'd2, 80'h0000_0000_0000_0000_0001, 1'b1, 1'b0, "R7");
    idle(1'b1, "R7");
    step(1'b0, 2'd0, 80'd0, 1'b1, 2'd1, 80'h8000000000000005, 1'b0, 1'b0, "R7");
    step(1'b1, 2'd0, 80'h3F800000, 1'b1, 2'd0, 80'h00000007, 1'b0, 1'b0, "R7");
    step(1'b1, 2'd1, 80'h4000000000000000, 1'b1, 2'd0, 80'h00000007, 1'b1, 1'b1, "R7");
    idle(1'b1, "R7");
    step(1'b1, 2'd0, 80'h3F000000, 1'b1, 2'd2, 80'h3FFF_8000_0000_0000_0000, 1'b0, 1'b0, "R7");
    // R8 clear and hit in the same cycle
    step(1'b1, 2'd0, 80'h00000100, 1'b0, 2'd0, 80'd0, 1'b1, 1'b1, "R8");
    idle(1'b0, "R8");

    // mixed traffic, R4 denormals forced often
    for (int i = 0; i < 400; i++) begin
      logic [79:0] d, c;
      logic [1:0]  f, cf;
      d  = {16'($urandom), $urandom, $urandom};
      c  = {16'($urandom), $urandom, $urandom};
      f  = 2'($urandom);
      cf = 2'($urandom);
      if ($urandom % 2 == 0) begin
        d[30:23] = 8'd0; d[62:52] = 11'd0; d[78:64] = 15'd0;
      end
      if ($urandom % 4 == 0) begin
        c[30:23] = 8'd0; c[62:52] = 11'd0; c[78:64] = 15'd0;
      end
      step(1'($urandom), f, d, ($urandom % 3 == 0), cf, c,
           1'($urandom), ($urandom % 8 == 0), "R4");
    end
    idle(1'b0, "R9");
    idle(1'b0, "R9");
    repeat (3) @(posedge clk);
    #2;
    check(q.size() == 0, "R9", "queue drained", 80'(q.size()), 80'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule